// File: doc/BRIEF.md
# Integer Execute Unit with Address Generation

This unit is the arithmetic stage of a small 32-bit load/store integer core. It receives the value of the first source register, a second operand that is either another register or a 16-bit immediate, an operation code and an immediate-extension mode. From these it forms the 32-bit value written back to the destination register. All paths are combinational, so the result settles in the same cycle as the inputs.

The unit covers wrapping add and subtract, signed set-less-than that returns 0 or 1, and placement of the immediate in the upper half of the word. It also forms memory addresses. The first address form is a base register plus a signed 16-bit byte offset. The second is a base plus a word index scaled by four, because memory is byte-addressed and successive 32-bit words sit four bytes apart.

A valid/ready pair passes through the unit with no storage. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A transfer completes on any cycle where both are high. When the consumer holds off, the producer must keep its inputs stable, and the result then stays stable too.

Top module: `alu_exec`

## Requirements
- R1: With `op_sel` = 0 (add), `result` = (`rs_val` + B) mod 2^32, where B is `rt_val` when `use_imm`=0 and the extended `imm16` when `use_imm`=1. No overflow indication exists.
- R2: With `op_sel` = 1 (subtract), `result` = (`rs_val` − B) mod 2^32, with B chosen as in R1.
- R3: With `op_sel` = 2 (set-less-than), `result` is 1 when `rs_val` < B as two's-complement signed values and 0 otherwise, with B chosen as in R1. Bits 31:1 are always zero.
- R4: With `op_sel` = 3 (upper immediate), `result[31:16]` = `imm16` and `result[15:0]` = 0, whatever the other operands are.
- R5: The immediate used as B is sign-extended from bit 15 when `imm_sext`=1 and zero-extended when `imm_sext`=0.
- R6: With `op_sel` = 4 (offset address), `result` = `rs_val` + sign-extended `imm16` mod 2^32. This holds whatever `use_imm` and `imm_sext` are.
- R7: With `op_sel` = 5 (indexed word address), `result` = (`rs_val` + 4·`rt_val`) mod 2^32.
- R8: `op_sel` values 6 and 7 give `result` = 0.
- R9: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. `result` depends only on the present inputs, whatever the handshake pins are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Producer presents an operation |
| in_ready | output | 1 | Unit can accept (mirrors `out_ready`) |
| op_sel | input | 3 | Operation code (see R1–R8) |
| use_imm | input | 1 | 1: second operand is the extended immediate |
| imm_sext | input | 1 | 1: sign-extend immediate, 0: zero-extend |
| rs_val | input | 32 | First source / base register value |
| rt_val | input | 32 | Second source / index register value |
| imm16 | input | 16 | Instruction immediate field |
| out_valid | output | 1 | Result is offered (mirrors `in_valid`) |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 32 | Writeback value or effective address |

## Verification
The assertions assume that inputs are settled, two-state values whenever they are sampled. They also assume that a producer keeps its operands stable while waiting out back-pressure. The bench meets this by changing inputs only just after a rising clock edge and comparing at the falling edge. It drives only defined values, including the undefined operation codes 6 and 7. The handshake pins are toggled independently of the operands, which shows that the result never depends on them.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W     = 32;
  localparam int IMM_W      = 16;
  localparam int WORD_SHIFT = 2;
  localparam int OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SLT  = 3'd2,
    OP_LUI  = 3'd3,
    OP_AOFS = 3'd4,
    OP_AIDX = 3'd5
  } alu_op_e;
endpackage

// File: rtl/imm_extend.sv
module imm_extend #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sext,
  output logic [DATA_W-1:0] ext
);
  localparam int FILL_W = DATA_W - IMM_W;

  logic fill_bit;

  always_comb begin
    fill_bit = sext & imm[IMM_W-1];
    ext      = {{FILL_W{fill_bit}}, imm};
  end
endmodule

// File: rtl/addsub.sv
module addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W:0]   wide;
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {W{sub}};
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
  end
endmodule

// File: rtl/slt_cmp.sv
module slt_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt
);
  logic [W-1:0] diff;
  logic         ovf;

  addsub #(.W(W)) u_diff (
    .a   (a),
    .b   (b),
    .sub (1'b1),
    .sum (diff)
  );

  always_comb begin
    ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
    lt  = diff[W-1] ^ ovf;
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DW  = alu_pkg::DATA_W,
  parameter int IW  = alu_pkg::IMM_W,
  parameter int WSH = alu_pkg::WORD_SHIFT
) (
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op_sel,
  input  logic          use_imm,
  input  logic          imm_sext,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] rt_val,
  input  logic [IW-1:0] imm16,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result
);
  localparam int LOW_W = DW - IW;

  logic [DW-1:0] imm_mode;
  logic [DW-1:0] imm_signed;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] arith_out;
  logic          is_sub;
  logic          lt_flag;
  logic [DW-1:0] agu_off;
  logic [DW-1:0] agu_out;
  logic [DW-1:0] lui_out;

  imm_extend #(.IMM_W(IW), .DATA_W(DW)) u_ext_mode (
    .imm  (imm16),
    .sext (imm_sext),
    .ext  (imm_mode)
  );

  imm_extend #(.IMM_W(IW), .DATA_W(DW)) u_ext_addr (
    .imm  (imm16),
    .sext (1'b1),
    .ext  (imm_signed)
  );

  always_comb begin
    opnd_b = use_imm ? imm_mode : rt_val;
    is_sub = (op_sel == OP_SUB);
  end

  addsub #(.W(DW)) u_arith (
    .a   (rs_val),
    .b   (opnd_b),
    .sub (is_sub),
    .sum (arith_out)
  );

  slt_cmp #(.W(DW)) u_slt (
    .a  (rs_val),
    .b  (opnd_b),
    .lt (lt_flag)
  );

  always_comb begin
    if (op_sel == OP_AIDX) agu_off = rt_val << WSH;
    else                   agu_off = imm_signed;
  end

  addsub #(.W(DW)) u_agu (
    .a   (rs_val),
    .b   (agu_off),
    .sub (1'b0),
    .sum (agu_out)
  );

  always_comb lui_out = {imm16, {LOW_W{1'b0}}};

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:   result = arith_out;
      OP_SLT:           result = {{(DW-1){1'b0}}, lt_flag};
      OP_LUI:           result = lui_out;
      OP_AOFS, OP_AIDX: result = agu_out;
      default:          result = '0;
    endcase
  end

  always_comb begin
    out_valid = in_valid;
    in_ready  = out_ready;
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk (
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  op_sel,
  input logic        use_imm,
  input logic        imm_sext,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [15:0] imm16,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] result
);
  logic [31:0] b_chk;

  always_comb begin
    if (use_imm) b_chk = imm_sext ? {{16{imm16[15]}}, imm16} : {16'h0, imm16};
    else         b_chk = rt_val;

    if (op_sel == 3'd1)
      a_r2_sub_inverse: assert (result + b_chk == rs_val);
    if (op_sel == 3'd2)
      a_r3_slt_bool: assert (result[31:1] == 31'h0);
    if (op_sel == 3'd3)
      a_r4_lui_place: assert (result[15:0] == 16'h0 && result[31:16] == imm16);
    if (op_sel == 3'd4)
      a_r6_agen_inverse: assert (result - {{16{imm16[15]}}, imm16} == rs_val);
    if (op_sel == 3'd5)
      a_r7_index_low: assert (result[1:0] == rs_val[1:0]);
    if (op_sel[2:1] == 2'b11)
      a_r8_unknown_zero: assert (result == 32'h0);
    a_r9_handshake: assert (out_valid == in_valid && in_ready == out_ready);
  end
endmodule

bind alu_exec alu_exec_chk u_chk (.*);

// File: tb/tb_alu_exec.sv
module tb_alu_exec;
  logic        clk = 1'b0;
  logic        in_valid, in_ready, use_imm, imm_sext, out_valid, out_ready;
  logic [2:0]  op_sel;
  logic [31:0] rs_val, rt_val, result;
  logic [15:0] imm16;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_exec dut (
    .in_valid (in_valid), .in_ready (in_ready), .op_sel (op_sel),
    .use_imm (use_imm), .imm_sext (imm_sext), .rs_val (rs_val),
    .rt_val (rt_val), .imm16 (imm16), .out_valid (out_valid),
    .out_ready (out_ready), .result (result)
  );

  function automatic logic [31:0] model(input int op, input bit ui, input bit se,
                                        input logic [31:0] a, input logic [31:0] t,
                                        input logic [15:0] im);
    longint ext, bv, sa, sb;
    ext = se ? longint'($signed(im)) : longint'(im);
    bv  = ui ? ext : longint'(t);
    case (op)
      0: return 32'(longint'(a) + bv);
      1: return 32'(longint'(a) - bv);
      2: begin
        sa = longint'($signed(a));
        sb = longint'($signed(32'(bv)));
        return (sa < sb) ? 32'd1 : 32'd0;
      end
      3: return {im, 16'h0};
      4: return 32'(longint'(a) + longint'($signed(im)));
      5: return 32'(longint'(a) + 4 * longint'(t));
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int op, input bit ui, input bit se);
    case (op)
      0: return (ui && !se) ? "R5/R1" : "R1";
      1: return (ui && !se) ? "R5/R2" : "R2";
      2: return (ui && !se) ? "R5/R3" : "R3";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input int op, input bit ui, input bit se, input logic [31:0] a,
                     input logic [31:0] t, input logic [15:0] im, input bit iv, input bit ordy);
    logic [31:0] exp;
    @(posedge clk);
    #1;
    op_sel = 3'(op); use_imm = ui; imm_sext = se;
    rs_val = a; rt_val = t; imm16 = im;
    in_valid = iv; out_ready = ordy;
    exp = model(op, ui, se, a, t, im);
    @(negedge clk);
    compared++;
    if (result !== exp) begin
      mismatched++;
      $display("FAIL %s op=%0d got %h expected %h", tag_of(op, ui, se), op, result, exp);
    end
    compared++;
    if (out_valid !== iv || in_ready !== ordy) begin
      mismatched++;
      $display("FAIL R9 got valid=%b ready=%b expected valid=%b ready=%b",
               out_valid, in_ready, iv, ordy);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    in_valid = 0; out_ready = 0; op_sel = 0; use_imm = 0; imm_sext = 0;
    rs_val = 0; rt_val = 0; imm16 = 0;
    @(negedge clk);
    compared++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0 || result !== 32'h0) begin
      mismatched++;
      $display("FAIL R9 idle got %b %b %h expected 0 0 0", out_valid, in_ready, result);
    end
    // R1 wrap and plain add
    run(0, 0, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1, 1);
    run(0, 0, 0, 32'd100, 32'd23, 16'h0, 1, 1);
    run(0, 1, 1, 32'd10, 32'h0, 16'hFFFF, 1, 0);       // R5 sign: 10 + -1
    run(0, 1, 0, 32'd10, 32'h0, 16'hFFFF, 0, 1);       // R5 zero: 10 + 65535
    // R2
    run(1, 0, 0, 32'd0, 32'd1, 16'h0, 1, 1);
    run(1, 1, 1, 32'd5, 32'h0, 16'h8000, 1, 1);
    // R3 signed compare corners
    run(2, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1, 1);
    run(2, 0, 0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1, 1);
    run(2, 0, 0, 32'd7, 32'd7, 16'h0, 1, 1);
    run(2, 1, 1, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 1, 1);
    run(2, 1, 0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 1, 1);
    run(2, 1, 1, 32'd0, 32'h0, 16'h8000, 1, 1);
    // R4 ignoring other inputs
    run(3, 0, 1, 32'hDEAD_BEEF, 32'h1234_5678, 16'hABCD, 1, 1);
    run(3, 1, 0, 32'h0, 32'h0, 16'h8001, 0, 0);
    // R6 offsets, mode pins ignored
    run(4, 0, 0, 32'h1000, 32'hFFFF, 16'd32, 1, 1);
    run(4, 1, 0, 32'h1000, 32'h0, 16'hFFFC, 1, 1);
    run(4, 0, 0, 32'h0000_0002, 32'h0, 16'h8000, 1, 1);
    // R7 word index
    run(5, 1, 1, 32'h2000, 32'd3, 16'hFFFF, 1, 1);
    run(5, 0, 0, 32'h0, 32'h4000_0001, 16'h0, 1, 1);
    // R8 unknown codes
    run(6, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1, 1);
    run(7, 1, 1, 32'h1234, 32'h5678, 16'h9ABC, 1, 0);
    // mixed pseudo-random sweep covering R1..R9
    for (int i = 0; i < 2000; i++) begin
      run(int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), $urandom, $urandom,
          16'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule